// File: doc/BRIEF.md
# Shared-Memory Hash Exact-Match Lookup

This block keeps several logical exact-match tables inside one physical word-addressed memory. Each logical table owns a window in that memory, given by a base word and a power-of-two entry count. A lookup carries a table number and a key. The block hashes the key with a 16-bit CRC, masks the hash down to the window size, adds the window base, reads that one word, and reports hit or miss with the stored action value. Nothing is searched by content. Each lookup costs one memory read.

Each stored word holds a valid flag, the key, the owning table number and the action value. Windows that never overlap need only a key compare. Windows that do overlap also need the stored owner to match the requesting table, and a per-table flag turns that owner check on. Software writes each table's window and flag through a configuration port. It adds or removes entries through an insert port, which hashes the key into the table's window the same way a lookup does. Collision chaining, multi-way buckets and placement policy are left to software.

The block has no state machine. It is a fixed pipeline: a hash-and-address stage, then a read-and-compare stage. Any mix of configuration writes, inserts and lookups may be issued in the same cycle.

Top module: `shared_hash_lookup`

## Requirements
- R1: While reset is asserted and after it is released, `lk_valid_o` and `lk_hit_o` are low, and every memory word is invalid, so lookups miss until an insert is made.
- R2: A lookup request sampled in cycle c produces exactly one `lk_valid_o` pulse in cycle c+2. Requests may be issued in consecutive cycles.
- R3: The hash is a CRC-16 with polynomial 0x1021 and seed 0xFFFF, fed with the key from its most significant bit down, with no reflection and no final XOR. The word address is (base + (crc AND (size-1))) modulo DEPTH, so a window wraps past the last word. A table of size 1 always addresses its base word.
- R4: A configuration write sets the base, size (zero or a power of two up to DEPTH) and owner-check flag of one table. The new values apply to requests issued from the next cycle on, and the other tables are left unchanged.
- R5: An insert writes {valid = `ins_vld_i`, owner, key, action} at the address the table's current window gives for the key. Writing with `ins_vld_i` = 0 deletes the entry at that address.
- R6: A lookup hits when the addressed word is valid and its key equals the lookup key. If the table's owner check is off, the stored owner is ignored.
- R7: If the table's owner check is on, a hit also needs the stored owner to equal the lookup's table number.
- R8: A table with size zero is unconfigured. Lookups to it always miss, and inserts to it write nothing.
- R9: On a miss, `lk_data_o` is zero. On a hit, it carries the stored action value.
- R10: A lookup issued one cycle before an insert to the same word sees the old content. A lookup issued in the same cycle as that insert, or later, sees the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_tid_i | input | TID_W | Table being configured |
| cfg_base_i | input | AW | Window base word |
| cfg_size_i | input | AW+1 | Window size in words (0 or a power of two) |
| cfg_idchk_i | input | 1 | Enable the stored-owner check for this table |
| ins_we_i | input | 1 | Insert strobe |
| ins_tid_i | input | TID_W | Owning table of the entry |
| ins_key_i | input | KEY_W | Entry key |
| ins_data_i | input | DATA_W | Entry action value |
| ins_vld_i | input | 1 | Valid flag to store (0 deletes) |
| lk_req_i | input | 1 | Lookup request |
| lk_tid_i | input | TID_W | Table searched |
| lk_key_i | input | KEY_W | Lookup key |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_data_o | output | DATA_W | Action value on a hit, zero otherwise |

## Verification
Every lookup result is due in the second cycle after its request cycle. The reference model in the bench therefore keeps a one-entry pending stage per edge and samples the outputs at the falling edge of that cycle. Configuration writes and inserts take effect at the edge that ends their own cycle. The model applies them only after it has resolved the read due at that edge, and this gives the R10 ordering without special cases. Directed lookups drive the request, wait two falling edges and compare against hand-derived values. Size-1 probe windows check the exact address of an entry.

// File: rtl/shlk_pkg.sv
package shlk_pkg;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // one serial CRC step, data bit shifted in at the top
    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return fb ? ((c << 1) ^ CRC_POLY) : (c << 1);
    endfunction
endpackage

// File: rtl/shlk_hash_addr.sv
module shlk_hash_addr #(
    parameter int KEY_W = 32,
    parameter int AW    = 10
) (
    input  logic [KEY_W-1:0] key_i,
    input  logic [AW-1:0]    base_i,
    input  logic [AW:0]      size_i,
    output logic [AW-1:0]    addr_o,
    output logic             en_o
);
    import shlk_pkg::*;

    logic [15:0]   crc;
    logic [AW-1:0] mask;
    logic [AW-1:0] off;

    always_comb begin
        crc = CRC_SEED;
        for (int i = KEY_W - 1; i >= 0; i--) begin
            crc = crc_bit(crc, key_i[i]);
        end
        mask   = AW'(size_i - 1'b1);
        off    = mask & AW'(crc);
        addr_o = base_i + off;
        en_o   = |size_i;
    end
endmodule

// File: rtl/shlk_cfg_regs.sv
module shlk_cfg_regs #(
    parameter int NT    = 4,
    parameter int AW    = 10,
    parameter int TID_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [TID_W-1:0] wtid_i,
    input  logic [AW-1:0]    wbase_i,
    input  logic [AW:0]      wsize_i,
    input  logic             wchk_i,
    input  logic [TID_W-1:0] a_tid_i,
    output logic [AW-1:0]    a_base_o,
    output logic [AW:0]      a_size_o,
    output logic             a_chk_o,
    input  logic [TID_W-1:0] b_tid_i,
    output logic [AW-1:0]    b_base_o,
    output logic [AW:0]      b_size_o
);
    logic [AW-1:0] base_q [NT];
    logic [AW:0]   size_q [NT];
    logic          chk_q  [NT];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int t = 0; t < NT; t++) begin
                base_q[t] <= '0;
                size_q[t] <= '0;
                chk_q[t]  <= 1'b0;
            end
        end else if (we_i) begin
            base_q[wtid_i] <= wbase_i;
            size_q[wtid_i] <= wsize_i;
            chk_q[wtid_i]  <= wchk_i;
        end
    end

    always_comb begin
        a_base_o = base_q[a_tid_i];
        a_size_o = size_q[a_tid_i];
        a_chk_o  = chk_q[a_tid_i];
        b_base_o = base_q[b_tid_i];
        b_size_o = size_q[b_tid_i];
    end

    for (genvar k = 0; k < NT; k++) begin : g_chk
        // R4
        other_tbl_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && wtid_i != TID_W'(k)) |=>
            ($stable(base_q[k]) && $stable(size_q[k]) && $stable(chk_q[k])));
        // R4
        own_tbl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && wtid_i == TID_W'(k)) |=>
            (size_q[k] == $past(wsize_i) && base_q[k] == $past(wbase_i)));
    end
endmodule

// File: rtl/shlk_entry_mem.sv
module shlk_entry_mem #(
    parameter int DEPTH  = 1024,
    parameter int AW     = 10,
    parameter int TID_W  = 2,
    parameter int KEY_W  = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic              wvld_i,
    input  logic [TID_W-1:0]  wtid_i,
    input  logic [KEY_W-1:0]  wkey_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic              rd_vld_o,
    output logic [TID_W-1:0]  rd_tid_o,
    output logic [KEY_W-1:0]  rd_key_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DEPTH-1:0]  vld_q;
    logic [TID_W-1:0]  tid_m  [DEPTH];
    logic [KEY_W-1:0]  key_m  [DEPTH];
    logic [DATA_W-1:0] data_m [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vld_q <= '0;
        end else if (we_i) begin
            vld_q[waddr_i] <= wvld_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            tid_m[waddr_i]  <= wtid_i;
            key_m[waddr_i]  <= wkey_i;
            data_m[waddr_i] <= wdata_i;
        end
    end

    // read returns the content from before a write at the same edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_vld_o  <= 1'b0;
            rd_tid_o  <= '0;
            rd_key_o  <= '0;
            rd_data_o <= '0;
        end else begin
            rd_vld_o  <= vld_q[raddr_i];
            rd_tid_o  <= tid_m[raddr_i];
            rd_key_o  <= key_m[raddr_i];
            rd_data_o <= data_m[raddr_i];
        end
    end

    // R5
    ins_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> (vld_q[$past(waddr_i)] == $past(wvld_i)));
endmodule

// File: rtl/shared_hash_lookup.sv
module shared_hash_lookup #(
    parameter int NUM_TABLES = 4,
    parameter int DEPTH      = 1024,
    parameter int KEY_W      = 32,
    parameter int DATA_W     = 16,
    localparam int AW        = $clog2(DEPTH),
    localparam int TID_W     = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [TID_W-1:0]  cfg_tid_i,
    input  logic [AW-1:0]     cfg_base_i,
    input  logic [AW:0]       cfg_size_i,
    input  logic              cfg_idchk_i,
    input  logic              ins_we_i,
    input  logic [TID_W-1:0]  ins_tid_i,
    input  logic [KEY_W-1:0]  ins_key_i,
    input  logic [DATA_W-1:0] ins_data_i,
    input  logic              ins_vld_i,
    input  logic              lk_req_i,
    input  logic [TID_W-1:0]  lk_tid_i,
    input  logic [KEY_W-1:0]  lk_key_i,
    output logic              lk_valid_o,
    output logic              lk_hit_o,
    output logic [DATA_W-1:0] lk_data_o
);
    logic [AW-1:0] lk_base, ins_base, lk_addr, ins_addr;
    logic [AW:0]   lk_size, ins_size;
    logic          lk_chk, lk_en, ins_en;

    shlk_cfg_regs #(.NT(NUM_TABLES), .AW(AW), .TID_W(TID_W)) cfg_u (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .we_i(cfg_we_i), .wtid_i(cfg_tid_i), .wbase_i(cfg_base_i),
        .wsize_i(cfg_size_i), .wchk_i(cfg_idchk_i),
        .a_tid_i(lk_tid_i), .a_base_o(lk_base), .a_size_o(lk_size), .a_chk_o(lk_chk),
        .b_tid_i(ins_tid_i), .b_base_o(ins_base), .b_size_o(ins_size)
    );

    shlk_hash_addr #(.KEY_W(KEY_W), .AW(AW)) lk_hash_u (
        .key_i(lk_key_i), .base_i(lk_base), .size_i(lk_size),
        .addr_o(lk_addr), .en_o(lk_en)
    );

    shlk_hash_addr #(.KEY_W(KEY_W), .AW(AW)) ins_hash_u (
        .key_i(ins_key_i), .base_i(ins_base), .size_i(ins_size),
        .addr_o(ins_addr), .en_o(ins_en)
    );

    // stage 1: hashed address and request context
    logic              s1_req_q, s1_chk_q, s1_en_q;
    logic [TID_W-1:0]  s1_tid_q;
    logic [KEY_W-1:0]  s1_key_q;
    logic [AW-1:0]     s1_addr_q;
    // stage 2: context aligned with read data
    logic              s2_req_q, s2_chk_q, s2_en_q;
    logic [TID_W-1:0]  s2_tid_q;
    logic [KEY_W-1:0]  s2_key_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_req_q <= 1'b0; s1_chk_q <= 1'b0; s1_en_q <= 1'b0;
            s1_tid_q <= '0;   s1_key_q <= '0;   s1_addr_q <= '0;
            s2_req_q <= 1'b0; s2_chk_q <= 1'b0; s2_en_q <= 1'b0;
            s2_tid_q <= '0;   s2_key_q <= '0;
        end else begin
            s1_req_q  <= lk_req_i;
            s1_chk_q  <= lk_chk;
            s1_en_q   <= lk_en;
            s1_tid_q  <= lk_tid_i;
            s1_key_q  <= lk_key_i;
            s1_addr_q <= lk_addr;
            s2_req_q  <= s1_req_q;
            s2_chk_q  <= s1_chk_q;
            s2_en_q   <= s1_en_q;
            s2_tid_q  <= s1_tid_q;
            s2_key_q  <= s1_key_q;
        end
    end

    logic              rd_vld;
    logic [TID_W-1:0]  rd_tid;
    logic [KEY_W-1:0]  rd_key;
    logic [DATA_W-1:0] rd_data;

    shlk_entry_mem #(.DEPTH(DEPTH), .AW(AW), .TID_W(TID_W), .KEY_W(KEY_W), .DATA_W(DATA_W)) mem_u (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .we_i(ins_we_i && ins_en), .waddr_i(ins_addr), .wvld_i(ins_vld_i),
        .wtid_i(ins_tid_i), .wkey_i(ins_key_i), .wdata_i(ins_data_i),
        .raddr_i(s1_addr_q),
        .rd_vld_o(rd_vld), .rd_tid_o(rd_tid), .rd_key_o(rd_key), .rd_data_o(rd_data)
    );

    logic match;
    always_comb begin
        match      = s2_en_q && rd_vld && (rd_key == s2_key_q) &&
                     (!s2_chk_q || rd_tid == s2_tid_q);
        lk_valid_o = s2_req_q;
        lk_hit_o   = s2_req_q && match;
        lk_data_o  = lk_hit_o ? rd_data : '0;
    end

    // R2
    latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_valid_o == $past(lk_req_i, 2));
    // R3
    window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_req_i && lk_en) |-> ({1'b0, AW'(lk_addr - lk_base)} < lk_size));
    // R8
    zero_size_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_req_i && !lk_en) |=> ##1 !lk_hit_o);
    // R6
    hit_has_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_hit_o |-> lk_valid_o);
endmodule

// File: tb/shared_hash_lookup_tb.sv
`timescale 1ns/1ps
module shared_hash_lookup_tb_top;
    localparam real CLK_NS = 8.0;
    localparam int  DEPTH  = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we, cfg_chk, ins_we, ins_vld, lk_req;
    logic [1:0]  cfg_tid, ins_tid, lk_tid;
    logic [9:0]  cfg_base;
    logic [10:0] cfg_size;
    logic [31:0] ins_key, lk_key;
    logic [15:0] ins_data;
    logic        lk_valid, lk_hit;
    logic [15:0] lk_data;

    always #(CLK_NS / 2.0) clk = ~clk;

    shared_hash_lookup dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_tid_i(cfg_tid), .cfg_base_i(cfg_base),
        .cfg_size_i(cfg_size), .cfg_idchk_i(cfg_chk),
        .ins_we_i(ins_we), .ins_tid_i(ins_tid), .ins_key_i(ins_key),
        .ins_data_i(ins_data), .ins_vld_i(ins_vld),
        .lk_req_i(lk_req), .lk_tid_i(lk_tid), .lk_key_i(lk_key),
        .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_data_o(lk_data)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";

    // ---------------- reference model ----------------
    bit          m_vld  [DEPTH];
    int unsigned m_tid  [DEPTH];
    logic [31:0] m_key  [DEPTH];
    logic [15:0] m_data [DEPTH];
    int unsigned c_base [4];
    int unsigned c_size [4];
    bit          c_chk  [4];
    bit          p_v, p_en, p_chk, e_v, e_hit;
    int unsigned p_a, p_tid;
    logic [31:0] p_key;
    logic [15:0] e_data;

    function automatic int unsigned ref_crc(input logic [31:0] k);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 31; i >= 0; i--) begin
            if (c[15] ^ k[i]) c = (c << 1) ^ 16'h1021;
            else              c = c << 1;
        end
        return int'(c);
    endfunction

    function automatic int unsigned ref_addr(input int unsigned base, input int unsigned size,
                                             input logic [31:0] k);
        return (base + (ref_crc(k) % size)) % DEPTH;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
            for (int t = 0; t < 4; t++) begin c_base[t] = 0; c_size[t] = 0; c_chk[t] = 0; end
            p_v = 0; e_v = 0; e_hit = 0; e_data = '0;
        end else begin
            e_v = p_v;
            e_hit = 0; e_data = '0;
            if (p_v && p_en && m_vld[p_a] && m_key[p_a] == p_key &&
                (!p_chk || m_tid[p_a] == p_tid)) begin
                e_hit = 1; e_data = m_data[p_a];
            end
            p_v = lk_req;
            if (lk_req) begin
                p_tid = lk_tid; p_key = lk_key; p_chk = c_chk[lk_tid];
                p_en  = c_size[lk_tid] != 0;
                p_a   = p_en ? ref_addr(c_base[lk_tid], c_size[lk_tid], lk_key) : 0;
            end
            if (ins_we && c_size[ins_tid] != 0) begin
                int unsigned a;
                a = ref_addr(c_base[ins_tid], c_size[ins_tid], ins_key);
                m_vld[a] = ins_vld; m_tid[a] = ins_tid; m_key[a] = ins_key; m_data[a] = ins_data;
            end
            if (cfg_we) begin
                c_base[cfg_tid] = cfg_base; c_size[cfg_tid] = cfg_size; c_chk[cfg_tid] = cfg_chk;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(lk_valid === e_v, "valid vs model", 32'(lk_valid), 32'(e_v));
            if (e_v) begin
                chk(lk_hit === e_hit, "hit vs model", 32'(lk_hit), 32'(e_hit));
                chk(lk_data === e_data, "data vs model", 32'(lk_data), 32'(e_data));
            end
        end
    end

    // ---------------- drivers ----------------
    task automatic clr();
        cfg_we = 0; ins_we = 0; lk_req = 0;
    endtask

    task automatic do_cfg(input int t, input int b, input int s, input bit c);
        @(negedge clk); clr();
        cfg_we = 1; cfg_tid = 2'(t); cfg_base = 10'(b); cfg_size = 11'(s); cfg_chk = c;
    endtask

    task automatic do_ins(input int t, input logic [31:0] k, input logic [15:0] d, input bit v);
        @(negedge clk); clr();
        ins_we = 1; ins_tid = 2'(t); ins_key = k; ins_data = d; ins_vld = v;
    endtask

    task automatic expect_look(input int t, input logic [31:0] k, input bit eh,
                               input logic [15:0] ed, input string why);
        @(negedge clk); clr();
        lk_req = 1; lk_tid = 2'(t); lk_key = k;
        @(negedge clk); clr();
        @(negedge clk);
        chk(lk_valid === 1'b1, {why, " valid"}, 32'(lk_valid), 32'd1);
        chk(lk_hit === eh, {why, " hit"}, 32'(lk_hit), 32'(eh));
        chk(lk_data === ed, {why, " data"}, 32'(lk_data), 32'(ed));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000.0);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    localparam logic [31:0] KA = 32'h1234_5678, KB = 32'hCAFE_0001, KC = 32'h0BAD_F00D;
    localparam logic [31:0] KE = 32'h7777_0E0E, KF = 32'h5A5A_A5A5;

    initial begin
        clr(); cfg_tid = 0; cfg_base = 0; cfg_size = 0; cfg_chk = 0;
        ins_tid = 0; ins_key = 0; ins_data = 0; ins_vld = 0; lk_tid = 0; lk_key = 0;
        repeat (4) @(negedge clk);
        tag = "R1";
        chk(lk_valid === 1'b0 && lk_hit === 1'b0, "outputs in reset", 32'(lk_valid), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(lk_valid === 1'b0, "valid after reset", 32'(lk_valid), 32'd0);

        tag = "R4";
        do_cfg(0, 0, 16, 0);
        do_cfg(1, 0, 16, 1);
        do_cfg(2, 0, 16, 0);
        tag = "R1";
        expect_look(0, KA, 0, 16'h0, "R1 empty memory miss");

        tag = "R6";
        do_ins(0, KA, 16'hA1A1, 1);
        expect_look(0, KA, 1, 16'hA1A1, "R6 own table hit");
        expect_look(2, KA, 1, 16'hA1A1, "R6 owner ignored when check off");
        tag = "R7";
        expect_look(1, KA, 0, 16'h0, "R7 owner mismatch misses");
        do_ins(1, KA, 16'hB2B2, 1);
        expect_look(1, KA, 1, 16'hB2B2, "R7 owner match hits");
        tag = "R9";
        expect_look(0, KB, 0, 16'h0, "R9 miss gives zero data");

        tag = "R3";
        do_cfg(3, int'(ref_crc(KA) % 16), 1, 0);
        expect_look(3, KA, 1, 16'hB2B2, "R3 probe exact address");
        do_cfg(2, 1020, 8, 0);
        do_ins(2, KC, 16'hC3C3, 1);
        do_cfg(3, int'((1020 + ref_crc(KC) % 8) % DEPTH), 1, 0);
        expect_look(3, KC, 1, 16'hC3C3, "R3 window wraps past top");

        tag = "R8";
        do_cfg(3, 0, 0, 0);
        expect_look(3, KA, 0, 16'h0, "R8 size-zero lookup misses");
        do_ins(3, KE, 16'hE5E5, 1);
        do_cfg(3, 0, 1024, 0);
        expect_look(3, KE, 0, 16'h0, "R8 insert to size-zero ignored");

        tag = "R4";
        @(negedge clk); clr();
        cfg_we = 1; cfg_tid = 3; cfg_base = 10'(ref_crc(KA) % 16); cfg_size = 1; cfg_chk = 0;
        lk_req = 1; lk_tid = 3; lk_key = KA;
        @(negedge clk); clr();
        lk_req = 1; lk_tid = 3; lk_key = KA;
        @(negedge clk); clr();
        chk(lk_hit === 1'b0, "R4 same-cycle lookup uses old config", 32'(lk_hit), 32'd0);
        @(negedge clk);
        chk(lk_hit === 1'b1, "R4 next-cycle lookup uses new config", 32'(lk_hit), 32'd1);

        tag = "R5";
        do_ins(0, KA, 16'h0, 0);
        expect_look(0, KA, 0, 16'h0, "R5 delete clears entry");

        tag = "R2";
        do_ins(0, KA, 16'h1111, 1);
        @(negedge clk); clr(); lk_req = 1; lk_tid = 0; lk_key = KA;
        @(negedge clk); lk_req = 1; lk_tid = 0; lk_key = KB;
        @(negedge clk); lk_req = 1; lk_tid = 1; lk_key = KA;
        chk(lk_valid && lk_hit && lk_data == 16'h1111, "R2 first of burst", 32'(lk_data), 32'h1111);
        @(negedge clk); clr();
        chk(lk_valid && !lk_hit, "R2 second of burst", 32'(lk_hit), 32'd0);
        @(negedge clk);
        chk(lk_valid && !lk_hit, "R2 third of burst", 32'(lk_hit), 32'd0);
        @(negedge clk);
        chk(lk_valid === 1'b0, "R2 single pulse per request", 32'(lk_valid), 32'd0);

        tag = "R10";
        @(negedge clk); clr(); lk_req = 1; lk_tid = 0; lk_key = KB;
        @(negedge clk); clr(); ins_we = 1; ins_tid = 0; ins_key = KB; ins_data = 16'hD4D4; ins_vld = 1;
        @(negedge clk); clr();
        chk(lk_hit === 1'b0, "R10 earlier lookup sees old word", 32'(lk_hit), 32'd0);
        @(negedge clk); clr();
        lk_req = 1; lk_tid = 0; lk_key = KF;
        ins_we = 1; ins_tid = 0; ins_key = KF; ins_data = 16'hF6F6; ins_vld = 1;
        @(negedge clk); clr();
        @(negedge clk);
        chk(lk_hit === 1'b1 && lk_data == 16'hF6F6, "R10 same-cycle lookup sees new word",
            32'(lk_data), 32'hF6F6);
        expect_look(0, KB, 1, 16'hD4D4, "R10 later lookup sees insert");

        tag = "R6 R7 R10 mixed";
        for (int n = 0; n < 600; n++) begin
            logic [31:0] keys [4];
            keys[0] = KA; keys[1] = KB; keys[2] = KC; keys[3] = KF;
            @(negedge clk); clr();
            if ($urandom % 8 == 0) begin
                cfg_we = 1; cfg_tid = 2'($urandom); cfg_base = 10'($urandom);
                cfg_size = ($urandom % 6 == 0) ? 11'd0 : 11'(1 << ($urandom % 5));
                cfg_chk = 1'($urandom);
            end
            if ($urandom % 3 == 0) begin
                ins_we = 1; ins_tid = 2'($urandom); ins_key = keys[$urandom % 4];
                ins_data = 16'($urandom); ins_vld = ($urandom % 4) != 0;
            end
            if ($urandom % 2 == 0) begin
                lk_req = 1; lk_tid = 2'($urandom); lk_key = keys[$urandom % 4];
            end
        end
        @(negedge clk); clr();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule